// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous static memory. Its word width and depth are set by parameters. The default is an 18-bit word of two 9-bit byte lanes and 256 locations. On each rising clock edge it captures the address, a chip select and the write controls. The write controls are a write-all strobe and one write strobe for each lane. Writes use a late-write protocol: the data for a write is sampled on the rising edge one cycle after the edge that took its command. The block holds that data in an internal pending-write buffer and moves it into the array on the following edge, with no further help from the requester.

Read data leaves through an output latch that loads on the falling edge of the same cycle in which the read command was captured. On a shared data bus the read can then be driven in the back half of its cycle. In a write-command cycle the output is released, which frees the bus for the late write data that follows. The pending buffer is checked on every read. A read of the address that sits in the buffer gets the buffered lanes merged over the array word.

An output enable and a sleep input act on the output drive without waiting for a clock. While sleep is high, the block takes no new commands and the array keeps its contents.

Top module: `late_write_sram`

## Requirements
- R1: While rstN is low, rdDrive is 0.
- R2: A read is chipSel=1, sleep=0, wrAll=0 and wrLane=0 at a rising edge. It raises rdDrive (if outEn=1) and presents the stored word on rdData from the next falling edge until the following falling edge.
- R3: For a write command captured at rising edge k, wrData is sampled at rising edge k+1. The value on wrData at edge k is not stored.
- R4: With wrAll=0, wrLane[i]=1 writes lane i only. Lane i is bits 9i+8 down to 9i, so lane 0 is bits 8:0 and lane 1 is bits 17:9. Lanes whose strobe is 0 keep their old value.
- R5: wrAll=1 writes every lane, whatever wrLane holds.
- R6: A read of the address of the pending write returns the newer data for the written lanes and array data for the rest. This applies even when the read comes in the cycle right after the write command, or while a different write is pending.
- R7: Back-to-back write commands on consecutive cycles all land, and none is lost.
- R8: A cycle with chipSel=0 is a no-op, and rdDrive is 0 after the falling edge of that cycle.
- R9: In a cycle whose command is a write, rdDrive is 0 after its falling edge.
- R10: outEn=0 forces rdDrive to 0 at once, without a clock edge. Setting outEn back to 1 restores a pending read's drive.
- R11: While sleep=1, commands are ignored and rdDrive is forced to 0 at once. The array contents are kept and can be read after sleep falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands and write data on rising edge, output latch on falling edge |
| rstN | input | 1 | Active-low asynchronous reset of control and output drive |
| chipSel | input | 1 | Synchronous select; 0 makes the cycle a no-op |
| wrAll | input | 1 | Write every byte lane |
| wrLane | input | LANES | Per-lane write strobes |
| addr | input | ADDR_W | Word address |
| wrData | input | WORD_W | Write data, presented one cycle after its command |
| outEn | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Power-down: blocks new commands, drops drive at once |
| rdData | output | WORD_W | Read data from the falling-edge latch |
| rdDrive | output | 1 | High when rdData should drive the shared bus |

## Verification
The bench checks a read in the cycle right after a write to the same address. A design without the pending-buffer bypass would return the stale array word there. It also reads one address while a write to another address is pending, which catches a bypass that ignores the address compare. Partial-lane writes followed by an immediate read catch a merge that picks the wrong lane or takes the whole buffered word. A write with decoy data on the bus in its command cycle catches a design that samples write data one cycle early. Sleep and output-enable toggles between clock edges catch gating that waits for a clock, and a write attempted during sleep must leave the stored word unchanged.

// File: rtl/late_write_sram_pkg.sv
package late_write_sram_pkg;

  // Strobes from the control to the datapath, valid between rising edges.
  typedef struct packed {
    logic readNow;    // read captured at the last rising edge
    logic loadPend;   // write captured at the last rising edge; data is on the bus now
    logic pendValid;  // pending buffer holds data to commit at the next rising edge
  } sramStrobes_t;

endpackage

// File: rtl/late_write_sram_ctrl.sv
module late_write_sram_ctrl
  import late_write_sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSel,
  input  logic             wrAll,
  input  logic [LANES-1:0] wrLane,
  input  logic             sleep,
  output sramStrobes_t     strb
);

  logic accept;
  logic isWrite;
  logic rdQ;
  logic wrQ;
  logic pendQ;

  assign accept  = chipSel & ~sleep;
  assign isWrite = wrAll | (|wrLane);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ   <= 1'b0;
      wrQ   <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      rdQ   <= accept & ~isWrite;
      wrQ   <= accept & isWrite;
      // Late data arriving this cycle fills the buffer; it retires next edge.
      pendQ <= wrQ;
    end
  end

  always_comb begin
    strb.readNow   = rdQ;
    strb.loadPend  = wrQ;
    strb.pendValid = pendQ;
  end

endmodule

// File: rtl/late_write_sram_dpath.sv
module late_write_sram_dpath
  import late_write_sram_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int LANES  = 2,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANE_W = WORD_W / LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrAll,
  input  logic [LANES-1:0]  wrLane,
  input  logic [WORD_W-1:0] wrData,
  input  sramStrobes_t      strb,
  output logic [WORD_W-1:0] dataQ,
  output logic              drvQ
);

  logic [WORD_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  maskQ;
  logic [ADDR_W-1:0] pendAddr;
  logic [LANES-1:0]  pendMask;
  logic [WORD_W-1:0] pendData;
  logic [WORD_W-1:0] memWord;
  logic [WORD_W-1:0] mergedWord;
  logic              pendHit;

  // Capture stage: address and lane mask every cycle; late data when due.
  always_ff @(posedge clk) begin
    addrQ <= addr;
    maskQ <= wrAll ? {LANES{1'b1}} : wrLane;
    if (strb.loadPend) begin
      pendAddr <= addrQ;
      pendMask <= maskQ;
      pendData <= wrData;
    end
  end

  // Self-timed retire of the pending buffer into the array.
  always_ff @(posedge clk) begin
    if (strb.pendValid) begin
      for (int l = 0; l < LANES; l++) begin
        if (pendMask[l]) begin
          mem[pendAddr][l*LANE_W +: LANE_W] <= pendData[l*LANE_W +: LANE_W];
        end
      end
    end
  end

  assign memWord = mem[addrQ];
  assign pendHit = strb.pendValid && (pendAddr == addrQ);

  // Per-lane bypass of the pending write over the array word.
  for (genvar g = 0; g < LANES; g++) begin : gLaneMerge
    assign mergedWord[g*LANE_W +: LANE_W] =
      (pendHit && pendMask[g]) ? pendData[g*LANE_W +: LANE_W]
                               : memWord[g*LANE_W +: LANE_W];
  end

  // Falling-edge output latch.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      drvQ <= 1'b0;
    end else begin
      drvQ <= strb.readNow;
    end
  end

  always_ff @(negedge clk) begin
    if (strb.readNow) begin
      dataQ <= mergedWord;
    end
  end

endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
  import late_write_sram_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int LANES  = 2,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              wrAll,
  input  logic [LANES-1:0]  wrLane,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              outEn,
  input  logic              sleep,
  output logic [WORD_W-1:0] rdData,
  output logic              rdDrive
);

  sramStrobes_t strb;
  logic         drvLatch;

  late_write_sram_ctrl #(
    .LANES(LANES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .chipSel(chipSel),
    .wrAll  (wrAll),
    .wrLane (wrLane),
    .sleep  (sleep),
    .strb   (strb)
  );

  late_write_sram_dpath #(
    .WORD_W(WORD_W),
    .LANES (LANES),
    .DEPTH (DEPTH)
  ) dpath_i (
    .clk   (clk),
    .rstN  (rstN),
    .addr  (addr),
    .wrAll (wrAll),
    .wrLane(wrLane),
    .wrData(wrData),
    .strb  (strb),
    .dataQ (rdData),
    .drvQ  (drvLatch)
  );

  // Asynchronous gating of the latched drive.
  assign rdDrive = drvLatch & outEn & ~sleep;

  // R1
  always_comb begin
    if (!rstN) begin
      reset_quiet_chk: assert (!rdDrive);
    end
  end

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && !sleep && !wrAll && (wrLane == '0)) |=> drvLatch);

  // R8
  deselect_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSel) |=> !drvLatch);

  // R9
  write_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && !sleep && (wrAll || (wrLane != '0))) |=> !drvLatch);

  // R11
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !drvLatch);

endmodule

// File: tb/late_write_sram_tb_top.sv
`timescale 1ns/1ps
module late_write_sram_tb_top;

  localparam int WW = 18;
  localparam int LN = 2;
  localparam int DP = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          chipSel = 1'b0;
  logic          wrAll = 1'b0;
  logic [LN-1:0] wrLane = '0;
  logic [7:0]    addr = '0;
  logic [WW-1:0] wrData = '0;
  logic          outEn = 1'b1;
  logic          sleep = 1'b0;
  logic [WW-1:0] rdData;
  logic          rdDrive;

  int checks = 0;
  int errors = 0;

  logic [WW-1:0] model [DP];
  bit            prevWr = 1'b0;
  int            prevAddr = 0;
  bit [1:0]      prevMask = 2'b00;

  always #2.5 clk = ~clk;

  late_write_sram dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .chipSel(chipSel),
    .wrAll  (wrAll),
    .wrLane (wrLane),
    .addr   (addr),
    .wrData (wrData),
    .outEn  (outEn),
    .sleep  (sleep),
    .rdData (rdData),
    .rdDrive(rdDrive)
  );

  task automatic chk(bit ok, string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit [WW-1:0] pat(int a);
    return bit'(1) ? WW'((a * 1031 + 7) & 18'h3FFFF) : '0;
  endfunction

  // One bus cycle: drive command and data, apply the reference at the edge,
  // then sample after the falling edge.
  task automatic cyc(bit s, bit g, bit [1:0] b, int a, bit [WW-1:0] d,
                     bit o, bit p, string label = "");
    bit valid, wr, rd, expOe;
    logic [WW-1:0] expData;
    string tag;
    chipSel = s; wrAll = g; wrLane = b; addr = a[7:0];
    wrData = d; outEn = o; sleep = p;
    @(posedge clk);
    if (prevWr) begin
      for (int l = 0; l < LN; l++) begin
        if (prevMask[l]) model[prevAddr][l*9 +: 9] = d[l*9 +: 9];
      end
    end
    valid    = s && !p;
    wr       = valid && (g || (b != 2'b00));
    rd       = valid && !wr;
    expData  = model[a];
    prevWr   = wr;
    prevAddr = a;
    prevMask = g ? 2'b11 : b;
    expOe    = rd && o && !p;
    if (label != "")  tag = label;
    else if (p)       tag = "R11";
    else if (!s)      tag = "R8";
    else if (wr)      tag = "R9";
    else if (!o)      tag = "R10";
    else              tag = "R2";
    #3;
    chk(rdDrive === expOe, tag, {17'b0, rdDrive}, {17'b0, expOe});
    if (expOe) chk(rdData === expData, tag, rdData, expData);
  endtask

  initial begin
    // R1: drive stays off during reset even with a read presented
    chipSel = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(rdDrive === 1'b0, "R1", {17'b0, rdDrive}, 18'h0);
    rstN = 1'b1;
    @(posedge clk);
    #1;

    // R7 / R5: fill every word with back-to-back full writes
    for (int a = 0; a < DP; a++) begin
      cyc(1, 1, 2'b00, a, (a == 0) ? 18'h0 : pat(a - 1), 1, 0, "R7");
    end
    cyc(0, 0, 2'b00, 0, pat(DP - 1), 1, 0, "R7");
    for (int a = 0; a < 8; a++) cyc(1, 0, 2'b00, a, 18'h0, 1, 0, "R7");
    cyc(1, 0, 2'b00, DP - 1, 18'h0, 1, 0, "R7");

    // R3: decoy on the bus in the command cycle, real data one cycle later
    cyc(1, 1, 2'b00, 10, 18'h15555, 1, 0, "R9");
    cyc(0, 0, 2'b00, 0, 18'h0ABCD, 1, 0, "R8");
    cyc(1, 0, 2'b00, 10, 18'h3FFFF, 1, 0, "R3");

    // R4 lane 0 then R6 immediate read with merge
    cyc(1, 0, 2'b01, 20, 18'h0, 1, 0, "R9");
    cyc(1, 0, 2'b00, 20, 18'h3FFFF, 1, 0, "R6");
    cyc(0, 0, 2'b00, 0, 18'h0, 1, 0, "R8");
    cyc(1, 0, 2'b00, 20, 18'h0, 1, 0, "R4");
    // R4 lane 1
    cyc(1, 0, 2'b10, 21, 18'h0, 1, 0, "R9");
    cyc(0, 0, 2'b00, 0, 18'h2AAAA, 1, 0, "R8");
    cyc(1, 0, 2'b00, 21, 18'h0, 1, 0, "R4");

    // R5: write-all overrides lane strobes
    cyc(1, 1, 2'b00, 22, 18'h0, 1, 0, "R9");
    cyc(0, 0, 2'b00, 0, 18'h12345, 1, 0, "R8");
    cyc(1, 0, 2'b00, 22, 18'h0, 1, 0, "R5");
    cyc(1, 1, 2'b01, 23, 18'h0, 1, 0, "R9");
    cyc(0, 0, 2'b00, 0, 18'h3C3C3, 1, 0, "R8");
    cyc(1, 0, 2'b00, 23, 18'h0, 1, 0, "R5");

    // R6: read of one address while a write to another is pending
    cyc(1, 1, 2'b00, 30, 18'h0, 1, 0, "R9");
    cyc(1, 0, 2'b10, 31, 18'h11111, 1, 0, "R9");
    cyc(1, 0, 2'b00, 30, 18'h2F0F0, 1, 0, "R6");
    cyc(1, 0, 2'b00, 31, 18'h0, 1, 0, "R6");

    // R8: deselect releases the output
    cyc(0, 0, 2'b00, 5, 18'h0, 1, 0, "R8");

    // R10: output enable acts without a clock
    cyc(1, 0, 2'b00, 5, 18'h0, 1, 0, "R2");
    outEn = 1'b0;
    #0.5;
    chk(rdDrive === 1'b0, "R10", {17'b0, rdDrive}, 18'h0);
    outEn = 1'b1;
    #0.5;
    chk(rdDrive === 1'b1, "R10", {17'b0, rdDrive}, 18'h1);

    // R11: asynchronous drop, ignored write, retained contents
    cyc(1, 0, 2'b00, 6, 18'h0, 1, 0, "R2");
    sleep = 1'b1;
    #0.5;
    chk(rdDrive === 1'b0, "R11", {17'b0, rdDrive}, 18'h0);
    sleep = 1'b0;
    cyc(1, 1, 2'b00, 40, 18'h0, 1, 1, "R11");
    cyc(0, 0, 2'b00, 0, 18'h3FFFF, 1, 1, "R11");
    cyc(1, 0, 2'b00, 40, 18'h0, 1, 1, "R11");
    cyc(1, 0, 2'b00, 40, 18'h0, 1, 0, "R11");

    // Mixed traffic against the reference on every cycle
    for (int i = 0; i < 3000; i++) begin
      bit s, g, p, o, w;
      bit [1:0] b;
      s = ($urandom % 8) != 0;
      w = ($urandom % 2) != 0;
      g = w && (($urandom % 3) == 0);
      b = w ? 2'($urandom % 4) : 2'b00;
      p = ($urandom % 20) == 0;
      o = ($urandom % 10) != 0;
      cyc(s, g, b, $urandom % DP, 18'($urandom), o, p);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule